// File: doc/BRIEF.md
# Base-Index Effective Address Generator

This block forms the memory operand address for a 16-bit segmented datapath. For a register form, a 3-bit mode picks one of eight base/index combinations of the BX, BP, SI and DI registers. A separate form-class input selects either those register forms, displacement-only (absolute) addressing, or addressing relative to the stack pointer SP. A displacement can be added to the result. It can be absent, a sign-extended byte, or a full word.

The sum wraps at 16 bits and gives the operand offset. The base register that was used decides the default segment. Forms built on BP or SP go to the stack segment. Everything else goes to the data segment. The block adds the 24-bit base of the chosen segment to the zero-extended offset to give a 24-bit physical address.

The logic is combinational up to a single output register stage. A request qualified by `in_valid` shows up one clock later with `out_valid` high. When no request is presented, the registered results hold their previous values. Instruction decode and segment override prefixes are handled elsewhere.

Top module: `ea_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_offset`, `out_phys` and `out_stack` are all cleared to zero.
- R2: A request with `in_valid` high at a clock edge produces `out_valid` high after that same edge. `out_valid` is low after every edge where `in_valid` was low.
- R3: For `form`=0, `mode` selects the register terms as follows: 0=BX+SI, 1=BX+DI, 2=BP+SI, 3=BP+DI, 4=SI, 5=DI, 6=BP, 7=BX.
- R4: Modes 0, 1, 4, 5 and 7, and displacement-only addressing, report the data segment (`out_stack`=0) and use `data_base`.
- R5: Modes 2, 3 and 6, and the SP-relative form, report the stack segment (`out_stack`=1) and use `stack_base`.
- R6: `disp_sz` encoding: 0 adds nothing, 1 adds `disp[7:0]` sign-extended to 16 bits, and 2 or 3 add all 16 bits of `disp`.
- R7: The offset is the register terms plus the displacement, taken modulo 2^16.
- R8: `out_phys` = (segment base + zero-extended `out_offset`) modulo 2^24.
- R9: `form` encoding: 0 selects the register forms, 1 or 3 select displacement-only addressing (offset = displacement alone), and 2 selects SP-relative addressing (offset = SP + displacement).
- R10: After an edge where `in_valid` is low, `out_offset`, `out_phys` and `out_stack` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier |
| form | input | 2 | Form class: register, displacement-only, SP-relative |
| mode | input | 3 | Base/index combination for register forms |
| disp_sz | input | 2 | Displacement size selector |
| disp | input | 16 | Displacement value |
| reg_bx | input | 16 | BX register value |
| reg_bp | input | 16 | BP register value |
| reg_si | input | 16 | SI register value |
| reg_di | input | 16 | DI register value |
| reg_sp | input | 16 | SP register value |
| data_base | input | 24 | Data segment base |
| stack_base | input | 24 | Stack segment base |
| out_valid | output | 1 | Result valid strobe |
| out_offset | output | 16 | Effective offset |
| out_phys | output | 24 | Physical address |
| out_stack | output | 1 | 1 = stack segment used, 0 = data segment |

## Verification
Term selection, displacement extension and segment choice all feed a single register stage. A wrong internal choice therefore shows up on the ports on the first edge after the faulty request. It appears as a wrong `out_offset`, or as a wrong `out_stack` together with an address built from the wrong segment base. The stimulus pushes register values and displacements across the 16-bit and 24-bit wrap points. Carry or truncation mistakes then change the visible low bits rather than hiding in bits that are cut off. The hold check changes every input while `in_valid` is low, so a register that loads without qualification is exposed on the very next edge.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int OFS_W  = 16;
    localparam int PHYS_W = 24;
    localparam int BYTE_W = 8;
    localparam int EXT_W  = OFS_W - BYTE_W;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [PHYS_W-1:0] phys_t;

    typedef enum logic [2:0] {
        M_BX_SI = 3'd0, M_BX_DI = 3'd1, M_BP_SI = 3'd2, M_BP_DI = 3'd3,
        M_SI    = 3'd4, M_DI    = 3'd5, M_BP    = 3'd6, M_BX    = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        F_REG = 2'd0, F_ABS = 2'd1, F_SPREL = 2'd2, F_ABS_ALT = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        D_NONE = 2'd0, D_BYTE = 2'd1, D_WORD = 2'd2, D_WORD_ALT = 2'd3
    } dsz_e;

    typedef struct packed {
        ofs_t base;
        ofs_t index;
        logic stack;
    } terms_t;

    typedef struct packed {
        ofs_t  offset;
        phys_t phys;
        logic  stack;
    } result_t;

    function automatic ofs_t sext_byte(input logic [BYTE_W-1:0] b);
        return {{EXT_W{b[BYTE_W-1]}}, b};
    endfunction

    function automatic phys_t zext_ofs(input ofs_t o);
        return {{(PHYS_W-OFS_W){1'b0}}, o};
    endfunction
endpackage

// File: rtl/ea_term_sel.sv
module ea_term_sel
    import ea_pkg::*;
(
    input  form_e  form,
    input  mode_e  mode,
    input  ofs_t   bx,
    input  ofs_t   bp,
    input  ofs_t   si,
    input  ofs_t   di,
    input  ofs_t   sp,
    output terms_t terms
);
    always_comb begin
        terms = '0;
        unique case (form)
            F_REG: begin
                unique case (mode)
                    M_BX_SI: begin terms.base = bx; terms.index = si; terms.stack = 1'b0; end
                    M_BX_DI: begin terms.base = bx; terms.index = di; terms.stack = 1'b0; end
                    M_BP_SI: begin terms.base = bp; terms.index = si; terms.stack = 1'b1; end
                    M_BP_DI: begin terms.base = bp; terms.index = di; terms.stack = 1'b1; end
                    M_SI:    begin terms.base = si; terms.stack = 1'b0; end
                    M_DI:    begin terms.base = di; terms.stack = 1'b0; end
                    M_BP:    begin terms.base = bp; terms.stack = 1'b1; end
                    M_BX:    begin terms.base = bx; terms.stack = 1'b0; end
                    default: terms = '0;
                endcase
            end
            F_SPREL: begin
                terms.base  = sp;
                terms.stack = 1'b1;
            end
            default: terms = '0;
        endcase
    end

    always_comb begin
        if (form == F_ABS || form == F_ABS_ALT)
            a_abs_zero_r9: assert (terms.base == '0 && terms.index == '0 && !terms.stack);
    end
endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_pkg::*;
(
    input  dsz_e dsz,
    input  ofs_t disp,
    output ofs_t disp_ext
);
    always_comb begin
        unique case (dsz)
            D_NONE:  disp_ext = '0;
            D_BYTE:  disp_ext = sext_byte(disp[BYTE_W-1:0]);
            default: disp_ext = disp;
        endcase
    end

    always_comb begin
        if (dsz == D_BYTE)
            a_byte_ext_r6: assert (disp_ext[OFS_W-1:BYTE_W] == '0 || disp_ext[OFS_W-1:BYTE_W] == '1);
    end
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        form,
    input  logic [2:0]        mode,
    input  logic [1:0]        disp_sz,
    input  logic [OFS_W-1:0]  disp,
    input  logic [OFS_W-1:0]  reg_bx,
    input  logic [OFS_W-1:0]  reg_bp,
    input  logic [OFS_W-1:0]  reg_si,
    input  logic [OFS_W-1:0]  reg_di,
    input  logic [OFS_W-1:0]  reg_sp,
    input  logic [PHYS_W-1:0] data_base,
    input  logic [PHYS_W-1:0] stack_base,
    output logic              out_valid,
    output logic [OFS_W-1:0]  out_offset,
    output logic [PHYS_W-1:0] out_phys,
    output logic              out_stack
);
    terms_t  terms;
    ofs_t    disp_ext;
    result_t nxt;
    result_t res_q;
    logic    vld_q;

    ea_term_sel u_terms (
        .form  (form_e'(form)),
        .mode  (mode_e'(mode)),
        .bx    (reg_bx),
        .bp    (reg_bp),
        .si    (reg_si),
        .di    (reg_di),
        .sp    (reg_sp),
        .terms (terms)
    );

    ea_disp_ext u_disp (
        .dsz      (dsz_e'(disp_sz)),
        .disp     (disp),
        .disp_ext (disp_ext)
    );

    always_comb begin
        nxt.offset = terms.base + terms.index + disp_ext;
        nxt.stack  = terms.stack;
        nxt.phys   = (terms.stack ? stack_base : data_base) + zext_ofs(nxt.offset);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= nxt;
        end
    end

    assign out_valid  = vld_q;
    assign out_offset = res_q.offset;
    assign out_phys   = res_q.phys;
    assign out_stack  = res_q.stack;

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && !rst));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> ($stable(out_offset) && $stable(out_phys) && $stable(out_stack)));

    p_phys_sum_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst)) |->
            out_phys == (out_stack ? $past(stack_base) : $past(data_base)) + zext_ofs(out_offset));

    p_sprel_stack_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(form) == 2'd2) |-> out_stack);

    p_abs_data_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(form[0])) |-> !out_stack);
endmodule

// File: tb/ea_addr_gen_test.sv
module ea_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  form;
    logic [2:0]  mode;
    logic [1:0]  disp_sz;
    logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di, reg_sp;
    logic [23:0] data_base, stack_base;
    logic        out_valid;
    logic [15:0] out_offset;
    logic [23:0] out_phys;
    logic        out_stack;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ea_addr_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .form(form), .mode(mode),
        .disp_sz(disp_sz), .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp),
        .reg_si(reg_si), .reg_di(reg_di), .reg_sp(reg_sp),
        .data_base(data_base), .stack_base(stack_base),
        .out_valid(out_valid), .out_offset(out_offset), .out_phys(out_phys),
        .out_stack(out_stack)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model built from the requirement text.
    task automatic expect_of(output logic [15:0] e_ofs, output logic e_stk, output logic [23:0] e_phys);
        logic [31:0] sum;
        logic [31:0] d;
        case (disp_sz)
            2'd0: d = 0;
            2'd1: d = disp[7] ? (32'hFFFFFF00 | disp[7:0]) : {24'd0, disp[7:0]};
            default: d = {16'd0, disp};
        endcase
        if (form == 2'd1 || form == 2'd3) begin sum = d; e_stk = 0; end
        else if (form == 2'd2) begin sum = reg_sp + d; e_stk = 1; end
        else begin
            case (mode)
                3'd0: begin sum = reg_bx + reg_si + d; e_stk = 0; end
                3'd1: begin sum = reg_bx + reg_di + d; e_stk = 0; end
                3'd2: begin sum = reg_bp + reg_si + d; e_stk = 1; end
                3'd3: begin sum = reg_bp + reg_di + d; e_stk = 1; end
                3'd4: begin sum = reg_si + d; e_stk = 0; end
                3'd5: begin sum = reg_di + d; e_stk = 0; end
                3'd6: begin sum = reg_bp + d; e_stk = 1; end
                default: begin sum = reg_bx + d; e_stk = 0; end
            endcase
        end
        e_ofs  = sum[15:0];
        e_phys = (e_stk ? stack_base : data_base) + {8'd0, e_ofs};
    endtask

    task automatic issue(input string req, input logic [1:0] f, input logic [2:0] m,
                         input logic [1:0] ds, input logic [15:0] dv);
        logic [15:0] e_ofs;
        logic        e_stk;
        logic [23:0] e_phys;
        @(negedge clk);
        form = f; mode = m; disp_sz = ds; disp = dv; in_valid = 1'b1;
        expect_of(e_ofs, e_stk, e_phys);
        @(posedge clk); #1;
        in_valid = 1'b0;
        check("R2", "out_valid", {31'd0, out_valid}, 32'd1);
        check(req, "offset", {16'd0, out_offset}, {16'd0, e_ofs});
        check(req, "stack", {31'd0, out_stack}, {31'd0, e_stk});
        check("R8", "phys", {8'd0, out_phys}, {8'd0, e_phys});
    endtask

    task automatic t_reset;
        check("R1", "valid", {31'd0, out_valid}, 0);
        check("R1", "offset", {16'd0, out_offset}, 0);
        check("R1", "phys", {8'd0, out_phys}, 0);
        check("R1", "stack", {31'd0, out_stack}, 0);
    endtask

    task automatic t_modes;
        reg_bx = 16'h1200; reg_bp = 16'h0340; reg_si = 16'h0056; reg_di = 16'h7000; reg_sp = 16'hFFF0;
        data_base = 24'h010000; stack_base = 24'h230000;
        for (int m = 0; m < 8; m++) begin
            if (m == 2 || m == 3 || m == 6) issue("R5", 2'd0, m[2:0], 2'd2, 16'h0008);
            else issue("R4", 2'd0, m[2:0], 2'd2, 16'h0008);
        end
        issue("R3", 2'd0, 3'd3, 2'd0, 16'hABCD);
    endtask

    task automatic t_disp;
        issue("R6", 2'd0, 3'd7, 2'd1, 16'h55F0);
        issue("R6", 2'd0, 3'd7, 2'd1, 16'hAA10);
        issue("R6", 2'd0, 3'd4, 2'd3, 16'h8001);
    endtask

    task automatic t_forms;
        issue("R9", 2'd1, 3'd6, 2'd2, 16'h4321);
        issue("R9", 2'd3, 3'd2, 2'd1, 16'h0080);
        issue("R9", 2'd2, 3'd0, 2'd1, 16'h0020);
        issue("R5", 2'd2, 3'd7, 2'd0, 16'h0000);
    endtask

    task automatic t_wrap;
        reg_bx = 16'hFFF0; reg_si = 16'h0030; reg_bp = 16'hFFFF; reg_di = 16'hFFFF;
        issue("R7", 2'd0, 3'd0, 2'd2, 16'hFFFF);
        issue("R7", 2'd0, 3'd3, 2'd1, 16'h00FE);
        data_base = 24'hFFFFF0; stack_base = 24'hFFFF00;
        issue("R8", 2'd0, 3'd0, 2'd0, 16'h0000);
        issue("R8", 2'd0, 3'd6, 2'd2, 16'h0200);
    endtask

    task automatic t_hold;
        logic [15:0] o;
        logic [23:0] p;
        logic        s;
        issue("R10", 2'd2, 3'd0, 2'd2, 16'h0100);
        o = out_offset; p = out_phys; s = out_stack;
        @(negedge clk);
        form = 2'd0; mode = 3'd4; disp = 16'h1234; disp_sz = 2'd2;
        reg_sp = 16'h0101; reg_si = 16'h0202; data_base = 24'h000777; stack_base = 24'h000888;
        @(posedge clk); #1;
        check("R2", "valid low", {31'd0, out_valid}, 0);
        check("R10", "offset held", {16'd0, out_offset}, {16'd0, o});
        check("R10", "phys held", {8'd0, out_phys}, {8'd0, p});
        check("R10", "stack held", {31'd0, out_stack}, {31'd0, s});
    endtask

    initial begin
        #1500000;
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; form = 0; mode = 0; disp_sz = 0; disp = 0;
        reg_bx = 0; reg_bp = 0; reg_si = 0; reg_di = 0; reg_sp = 0;
        data_base = 0; stack_base = 0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_modes();
        t_disp();
        t_forms();
        t_wrap();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule